// File: doc/BRIEF.md
# Accumulator Machine Hardwired Sequencer

This block is the hardwired control and datapath core of a 16-bit machine with a single accumulator. A 3-bit timing-step counter walks every instruction through fetch, decode, an optional indirect-address read, and execute. The core owns the program counter, the address register, the instruction register, a data register, the accumulator and the carry flag. It reaches a 4096-word memory through one word-wide read/write port. That port is always addressed by the address register.

Words whose opcode field is 7 are not executed here, apart from the halt word. Such a word is passed out on a one-cycle start pulse, and the core stalls until a done strobe returns. Register-reference and I/O operations can then be carried out by a neighbouring unit. The halt word stops the sequencer until the next reset.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous active-low reset clears PC, AC, E and the step counter, deasserts `halted`, `mem_we` and `xfer_start`, and starts fetching at address 0.
- R2: Each instruction is fetched from the word addressed by PC, and PC advances by exactly one during the fetch, so PC always holds the address of the next instruction.
- R3: An instruction word is decoded as follows: bit 15 is the addressing-mode bit, bits 14..12 are the opcode, and bits 11..0 are the address. Opcodes 0..6 are AND, ADD, load, store, branch, branch-to-subroutine and increment-skip-if-zero.
- R4: With mode bit 1, the word at the address field supplies the effective address through one extra memory read (its low 12 bits). With mode bit 0, the address field is the effective address.
- R5: AND (0) and ADD (1) combine AC with the memory operand, and load (2) copies the operand into AC. ADD writes bit 16 of the 17-bit sum into E. AND and load leave E unchanged.
- R6: Store (3) writes AC to memory at the effective address and changes nothing else.
- R7: Branch (4) loads PC with the effective address.
- R8: Branch-to-subroutine (5) writes the return address (the current PC, zero-extended) to memory at the effective address, then sets PC to the effective address plus one.
- R9: Increment-skip (6) reads the word at the effective address, adds one modulo 2^16 and writes the result back. If the result is zero, PC advances by one more.
- R10: Any word with opcode 7, other than the halt word, raises `xfer_start` for exactly one cycle with the word on `xfer_word`. The core then waits, leaving AC, E and PC untouched, until `xfer_done` is seen, and then fetches the next instruction.
- R11: The halt word 16'h7001 (mode 0, opcode 7, address 1) sets `halted`. After that, PC holds still and no memory write occurs until reset.
- R12: `mem_we` is raised only during the execute steps of store, branch-to-subroutine and increment-skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory word address (the address register) |
| mem_rdata | input | 16 | Memory read data, combinational from `mem_addr` |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable, written at the clock edge |
| xfer_start | output | 1 | One-cycle pulse passing an opcode-7 word out |
| xfer_word | output | 16 | The word being passed out |
| xfer_done | input | 1 | Strobe from the neighbour, ends the wait |
| halted | output | 1 | High once the halt word has executed |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |
| e_out | output | 1 | Carry flag E |

## Verification
The bench builds the core with its default address width of 12, which gives a 16-bit word and a 4096-word memory model. Each instruction uses exactly the field positions that the requirements list. At that width, wrap-around cases can be reached with short programs: an ADD whose sum carries out of bit 15, and an increment of 16'hFFFF that produces zero and skips. Direct and indirect forms, the subroutine link and the hand-off of opcode-7 words are each exercised.

// File: rtl/acc_seq_pkg.sv
// Package: shared codes for the accumulator sequencer.
// Assumes the opcode field is 3 bits wide and sits just below the mode bit.
package acc_seq_pkg;

    localparam int OPC_W  = 3;
    localparam int STEP_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_XTD = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_AND  = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_PASS = 2'd2,
        ALU_INC  = 2'd3
    } alu_op_e;

endpackage

// File: rtl/acc_seq_step.sv
// Module: timing-step counter.
// Clear has priority over load, and load has priority over increment.
// Assumes at most one instruction runs 7 steps (0..6).
module acc_seq_step
    import acc_seq_pkg::*;
#(
    parameter int LAST_STEP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [STEP_W-1:0] ld_val,
    input  logic              inc,
    output logic [STEP_W-1:0] step
);

    // Advance, jump or restart the step count.
    always_ff @(posedge clk) begin
        if (!rst_n)   step <= '0;
        else if (clr) step <= '0;
        else if (ld)  step <= ld_val;
        else if (inc) step <= step + 1'b1;
    end

    // R1
    sc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step <= STEP_W'(LAST_STEP));

endmodule

// File: rtl/acc_seq_decode.sv
// Module: instruction field decoder.
// Splits a word into the mode bit, the opcode and the address, and classifies it.
// Assumes DATA_W = ADDR_W + 4.
module acc_seq_decode
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int DATA_W = ADDR_W + OPC_W + 1
) (
    input  logic [DATA_W-1:0] word,
    output logic              mode,
    output opcode_e           opc,
    output logic [ADDR_W-1:0] addr,
    output logic              is_mem,
    output logic              is_halt,
    output logic              is_xfer
);

    localparam logic [DATA_W-1:0] HALT_WORD = {1'b0, OP_XTD, {(ADDR_W-1){1'b0}}, 1'b1};

    // Field split and class of the word.
    always_comb begin
        mode    = word[DATA_W-1];
        opc     = opcode_e'(word[DATA_W-2:ADDR_W]);
        addr    = word[ADDR_W-1:0];
        is_mem  = (opc != OP_XTD);
        is_halt = (word == HALT_WORD);
        is_xfer = (opc == OP_XTD) && !is_halt;
    end

endmodule

// File: rtl/acc_seq_alu.sv
// Module: accumulator ALU.
// Combinational. Produces a result word and the carry out of an add.
module acc_seq_alu
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              carry
);

    logic [DATA_W:0] sum;

    // Select the result for the requested operation.
    always_comb begin
        sum   = {1'b0, a} + {1'b0, b};
        carry = 1'b0;
        unique case (op)
            ALU_AND:  y = a & b;
            ALU_ADD:  begin y = sum[DATA_W-1:0]; carry = sum[DATA_W]; end
            ALU_PASS: y = b;
            ALU_INC:  y = b + 1'b1;
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/acc_seq_core.sv
// Module: hardwired sequencer and datapath of a single-accumulator machine.
// Steps: 0 AR<-PC, 1 IR<-M PC++, 2 decode, 3 indirect read, 4..6 execute.
// Assumes memory read data is combinational from mem_addr and writes land at the edge.
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int DATA_W = ADDR_W + OPC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              xfer_start,
    output logic [DATA_W-1:0] xfer_word,
    input  logic              xfer_done,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out,
    output logic              e_out
);

    localparam logic [STEP_W-1:0] S_FETCH_A = 3'd0;
    localparam logic [STEP_W-1:0] S_FETCH_B = 3'd1;
    localparam logic [STEP_W-1:0] S_DECODE  = 3'd2;
    localparam logic [STEP_W-1:0] S_INDIR   = 3'd3;
    localparam logic [STEP_W-1:0] S_EX0     = 3'd4;
    localparam logic [STEP_W-1:0] S_EX1     = 3'd5;
    localparam logic [STEP_W-1:0] S_EX2     = 3'd6;

    logic [ADDR_W-1:0] pc, ar;
    logic [DATA_W-1:0] ir, dr, ac;
    logic              e_q, halted_q, wait_q, start_q;
    logic [STEP_W-1:0] step;

    logic              mode, is_mem, is_halt, is_xfer;
    opcode_e           opc;
    logic [ADDR_W-1:0] f_addr;

    alu_op_e           alu_op;
    logic [DATA_W-1:0] alu_y;
    logic              alu_c;

    logic run, at_dec, at_ex0, at_ex1, at_ex2;
    logic sc_clr, sc_ld, sc_inc, end_instr;

    acc_seq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word    (ir),
        .mode    (mode),
        .opc     (opc),
        .addr    (f_addr),
        .is_mem  (is_mem),
        .is_halt (is_halt),
        .is_xfer (is_xfer)
    );

    acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (alu_op),
        .a     (ac),
        .b     (dr),
        .y     (alu_y),
        .carry (alu_c)
    );

    acc_seq_step #(.LAST_STEP(6)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sc_clr),
        .ld     (sc_ld),
        .ld_val (S_EX0),
        .inc    (sc_inc),
        .step   (step)
    );

    // Step qualifiers and the end-of-instruction decode.
    always_comb begin
        run    = !halted_q && !wait_q;
        at_dec = run && (step == S_DECODE);
        at_ex0 = run && (step == S_EX0);
        at_ex1 = run && (step == S_EX1);
        at_ex2 = run && (step == S_EX2);
        end_instr = (at_ex0 && (opc == OP_STA || opc == OP_BUN))
                 || (at_ex1 && (opc == OP_AND || opc == OP_ADD || opc == OP_LDA || opc == OP_BSA))
                 || (at_ex2 && (opc == OP_ISZ));
        sc_clr = end_instr || (at_dec && !is_mem);
        sc_ld  = at_dec && is_mem && !mode;
        sc_inc = run && !sc_clr && !sc_ld;
    end

    // ALU operation for the execute step that loads AC or bumps DR.
    always_comb begin
        unique case (opc)
            OP_AND:  alu_op = ALU_AND;
            OP_ADD:  alu_op = ALU_ADD;
            OP_ISZ:  alu_op = ALU_INC;
            default: alu_op = ALU_PASS;
        endcase
    end

    // Memory write port: data and enable per execute step.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = ac;
        if (at_ex0 && opc == OP_STA) begin
            mem_we = 1'b1;
        end else if (at_ex0 && opc == OP_BSA) begin
            mem_we    = 1'b1;
            mem_wdata = {{(DATA_W-ADDR_W){1'b0}}, pc};
        end else if (at_ex2 && opc == OP_ISZ) begin
            mem_we    = 1'b1;
            mem_wdata = dr;
        end
    end

    // Address register: fetch address, effective address, subroutine link.
    always_ff @(posedge clk) begin
        if (!rst_n) ar <= '0;
        else if (run && step == S_FETCH_A) ar <= pc;
        else if (at_dec && is_mem) ar <= f_addr;
        else if (run && step == S_INDIR) ar <= mem_rdata[ADDR_W-1:0];
        else if (at_ex0 && opc == OP_BSA) ar <= ar + 1'b1;
    end

    // Program counter: fetch increment, branches, skip.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else if (run && step == S_FETCH_B) pc <= pc + 1'b1;
        else if (at_ex0 && opc == OP_BUN) pc <= ar;
        else if (at_ex1 && opc == OP_BSA) pc <= ar;
        else if (at_ex2 && opc == OP_ISZ && dr == '0) pc <= pc + 1'b1;
    end

    // Instruction register: loaded from memory in the second fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) ir <= '0;
        else if (run && step == S_FETCH_B) ir <= mem_rdata;
    end

    // Data register: operand capture and the increment of increment-skip.
    always_ff @(posedge clk) begin
        if (!rst_n) dr <= '0;
        else if (at_ex0 && (opc == OP_AND || opc == OP_ADD || opc == OP_LDA || opc == OP_ISZ))
            dr <= mem_rdata;
        else if (at_ex1 && opc == OP_ISZ) dr <= alu_y;
    end

    // Accumulator and carry: written only from the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac  <= '0;
            e_q <= 1'b0;
        end else if (at_ex1 && (opc == OP_AND || opc == OP_ADD || opc == OP_LDA)) begin
            ac <= alu_y;
            if (opc == OP_ADD) e_q <= alu_c;
        end
    end

    // Halt latch and the hand-off wait with its start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            wait_q   <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= at_dec && is_xfer;
            if (at_dec && is_halt) halted_q <= 1'b1;
            if (at_dec && is_xfer) wait_q <= 1'b1;
            else if (wait_q && xfer_done) wait_q <= 1'b0;
        end
    end

    assign mem_addr   = ar;
    assign xfer_start = start_q;
    assign xfer_word  = ir;
    assign halted     = halted_q;
    assign pc_out     = pc;
    assign acc_out    = ac;
    assign e_out      = e_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && ac == '0 && !e_q && !halted_q && step == '0));

    // R2
    fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == S_FETCH_B) |=> pc == $past(pc) + 1'b1);

    // R10
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R10
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && !xfer_done) |=> ($stable(pc) && $stable(ac) && $stable(e_q)));

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (halted_q && $stable(pc) && !mem_we));

    // R12
    we_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (step >= S_EX0));

endmodule

// File: tb/tb_acc_seq_core.sv
module tb_acc_seq_core;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, mem_wdata, xfer_word;
    logic          mem_we, xfer_start, halted, e_out;
    logic          xfer_done = 1'b0;
    logic [AW-1:0] pc_out;
    logic [DW-1:0] acc_out;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        string         tag;
        logic [DW-1:0] ac;
        logic          e;
        logic [AW-1:0] pc;
        logic [AW-1:0] a0;
        logic [DW-1:0] d0;
        logic [AW-1:0] a1;
        logic [DW-1:0] d1;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] xfer_exp[$];
    logic          prev_halt = 1'b0;
    logic          monitor_done = 1'b0;

    acc_seq_core #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .xfer_start(xfer_start),
        .xfer_word(xfer_word), .xfer_done(xfer_done), .halted(halted),
        .pc_out(pc_out), .acc_out(acc_out), .e_out(e_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: on the rise of halted, pop the expected end state and compare.
    always @(negedge clk) begin
        if (rst_n && halted && !prev_halt && sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            check({x.tag, " AC"}, 32'(acc_out), 32'(x.ac));
            check({x.tag, " E"},  32'(e_out),   32'(x.e));
            check({x.tag, " PC"}, 32'(pc_out),  32'(x.pc));
            check({x.tag, " mem0"}, 32'(mem[x.a0]), 32'(x.d0));
            check({x.tag, " mem1"}, 32'(mem[x.a1]), 32'(x.d1));
            monitor_done = 1'b1;
        end
        prev_halt <= halted;
    end

    // Neighbour model: acknowledge each handed-off word two cycles later (R10).
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_start) begin
                if (xfer_exp.size() == 0) check("R10 unexpected start", 32'(xfer_word), 32'hFFFF_FFFF);
                else check("R10 xfer word", 32'(xfer_word), 32'(xfer_exp.pop_front()));
                check("R10 AC untouched while waiting", 32'(acc_out), 32'h0);
                @(negedge clk);
                @(negedge clk);
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    endtask

    // Driver: reset, push the expectation, release, wait for halt, check hold.
    task automatic run_prog(input exp_t x);
        int t;
        logic [AW-1:0] pc_at_halt;
        int we_seen;
        @(negedge clk);
        rst_n = 1'b0;
        sb.push_back(x);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        monitor_done = 1'b0;
        t = 0;
        while (!monitor_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!monitor_done) begin
            check({x.tag, " R11 timeout"}, 32'(halted), 32'd1);
            void'(sb.pop_front());
        end
        pc_at_halt = pc_out;
        we_seen = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (mem_we) we_seen++;
        end
        check({x.tag, " R11 PC held"}, 32'(pc_out), 32'(pc_at_halt));
        check({x.tag, " R11 no write"}, 32'(we_seen), 32'd0);
    endtask

    initial begin
        exp_t x;
        clear_mem();
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 PC", 32'(pc_out), 32'h0);
        check("R1 AC", 32'(acc_out), 32'h0);
        check("R1 E", 32'(e_out), 32'h0);
        check("R1 halted", 32'(halted), 32'h0);
        check("R1 we", 32'(mem_we), 32'h0);

        // R5 R6 R2: direct load, add with carry, store
        clear_mem();
        mem[0] = 16'h2010; mem[1] = 16'h1011; mem[2] = 16'h3012; mem[3] = 16'h7001;
        mem[12'h010] = 16'hFFFF; mem[12'h011] = 16'h0003;
        x = '{"R5/R6 direct", 16'h0002, 1'b1, 12'h004, 12'h012, 16'h0002, 12'h010, 16'hFFFF};
        run_prog(x);

        // R4 R3: indirect load, AND, store
        clear_mem();
        mem[0] = 16'hA020; mem[1] = 16'h8021; mem[2] = 16'hB022; mem[3] = 16'h7001;
        mem[12'h020] = 16'h0030; mem[12'h030] = 16'hF0F0;
        mem[12'h021] = 16'h0031; mem[12'h031] = 16'h3C3C;
        mem[12'h022] = 16'h0032;
        x = '{"R4 indirect", 16'h3030, 1'b0, 12'h004, 12'h032, 16'h3030, 12'h022, 16'h0032};
        run_prog(x);

        // R7 R8: branch, subroutine call, indirect return
        clear_mem();
        mem[0] = 16'h4005; mem[1] = 16'h7001;
        mem[5] = 16'h5040; mem[6] = 16'h7001;
        mem[12'h041] = 16'h2050; mem[12'h042] = 16'hC040;
        mem[12'h050] = 16'h1234;
        x = '{"R7/R8 branch", 16'h1234, 1'b0, 12'h007, 12'h040, 16'h0006, 12'h001, 16'h7001};
        run_prog(x);

        // R9: increment-skip with wrap to zero, then indirect without skip
        clear_mem();
        mem[0] = 16'h6010; mem[1] = 16'h7001; mem[2] = 16'hE011; mem[3] = 16'h7001;
        mem[12'h010] = 16'hFFFF; mem[12'h011] = 16'h0012; mem[12'h012] = 16'h0005;
        x = '{"R9 isz", 16'h0000, 1'b0, 12'h004, 12'h010, 16'h0000, 12'h012, 16'h0006};
        run_prog(x);

        // R10: opcode-7 words handed off, then a load
        clear_mem();
        mem[0] = 16'h7800; mem[1] = 16'hF400; mem[2] = 16'h2010; mem[3] = 16'h7001;
        mem[12'h010] = 16'h00AB;
        xfer_exp.push_back(16'h7800);
        xfer_exp.push_back(16'hF400);
        x = '{"R10 handoff", 16'h00AB, 1'b0, 12'h004, 12'h010, 16'h00AB, 12'h000, 16'h7800};
        run_prog(x);
        check("R10 all words handed off", 32'(xfer_exp.size()), 32'd0);

        // R12: no write during a program of loads only
        clear_mem();
        mem[0] = 16'h2003; mem[1] = 16'h7001; mem[3] = 16'h5555;
        x = '{"R12 load only", 16'h5555, 1'b0, 12'h002, 12'h003, 16'h5555, 12'h000, 16'h2003};
        run_prog(x);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles >= 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule